// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block collects interrupt requests from a set of device sources and distributes them to a small group of processors. Any source can be posted or cleared by index. The posted sources are held in a raw request vector. Each processor has its own enable mask. From these, the block derives a pending vector for each processor, which is the set of posted sources that the processor's mask accepts.

Each processor receives a level interrupt line. The line is high while its pending vector has any bit set. The block also reports the lowest-numbered pending source for each processor. A count input says how many processors are present, and the block never routes to a processor whose index is at or above that count.

All state is registered. A post, a clear, a mask write or a change in the present count is visible on the outputs one clock edge later. Raw, mask and pending state all advance on that same edge.

Top module: `irq_router`

## Requirements
- R1: A post of source n (`post_en` high, `post_src` = n) sets bit n of `raw_req` at the next rising edge. Other raw bits are left as they were.
- R2: After every edge, the pending slice of processor c (`pend[c*NSRC +: NSRC]`) equals that processor's mask ANDed with `raw_req`, when c is below the present count.
- R3: `irq[c]` is high exactly when the pending slice of processor c has at least one bit set. A post of a source that the mask accepts raises the line one cycle later.
- R4: A clear of source n whose raw bit is set clears raw bit n and pending bit n of every processor at the next edge. A processor's line falls if no other pending bit remains.
- R5: A clear of a source whose raw bit is not set changes no output.
- R6: When a post and a clear name the same source in the same cycle, the clear wins and the raw bit ends low. When they name different sources, both take effect.
- R7: A processor with index at or above `cpu_count` has an all-zero pending slice and a low `irq` line from the edge after the count is sampled.
- R8: A mask write (`mask_we` high, `mask_sel` = c, value `mask_val`) replaces the mask of processor c. That processor's pending slice and line reflect the new mask at the same edge.
- R9: `low_src[c*SW +: SW]` gives the smallest index set in the pending slice of processor c, and reads 0 when that slice is empty.
- R10: While `rst_n` is low, the raw vector, every mask and every pending slice are cleared. After reset, a post therefore reaches no processor until a mask is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_count | input | PW | Number of present processors (0..NCPU) |
| post_en | input | 1 | Post strobe |
| post_src | input | SW | Source index to post |
| clr_en | input | 1 | Clear strobe |
| clr_src | input | SW | Source index to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | CW | Processor whose mask is written |
| mask_val | input | NSRC | New mask value |
| raw_req | output | NSRC | Raw request vector |
| pend | output | NCPU*NSRC | Pending vectors, processor c in bits c*NSRC +: NSRC |
| irq | output | NCPU | Level interrupt per processor |
| low_src | output | NCPU*SW | Lowest pending source per processor |

## Verification
The bound checker checks several rules on every cycle:
- posts and clears land on the named raw bit, and a clear beats a post;
- the raw vector holds when idle;
- no pending bit exists without its raw bit;
- absent processors stay silent;
- a raised line points at a set pending bit with nothing lower.

The exact pending contents after a mask write, and the full post and clear sweeps across every source and processor count, need the bench. The bench compares against its own model of masks and raw state, because the masks are not visible at the ports.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC = 64,
  parameter int NCPU = 4,
  localparam int SW = $clog2(NSRC),
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int PW = $clog2(NCPU + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PW-1:0]        cpu_count,
  input  logic                 post_en,
  input  logic [SW-1:0]        post_src,
  input  logic                 clr_en,
  input  logic [SW-1:0]        clr_src,
  input  logic                 mask_we,
  input  logic [CW-1:0]        mask_sel,
  input  logic [NSRC-1:0]      mask_val,
  output logic [NSRC-1:0]      raw_req,
  output logic [NCPU*NSRC-1:0] pend,
  output logic [NCPU-1:0]      irq,
  output logic [NCPU*SW-1:0]   low_src
);

  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  logic [NSRC-1:0] raw_q, raw_d, set_v, clr_v;

  assign set_v = post_en ? (ONE << post_src) : '0;
  assign clr_v = clr_en  ? (ONE << clr_src)  : '0;
  assign raw_d = (raw_q | set_v) & ~clr_v;

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_d;
  end

  assign raw_req = raw_q;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NSRC-1:0] mask_q, mask_d, pend_q;
    logic [SW-1:0]   low;
    logic            here;

    assign here   = PW'(c) < cpu_count;
    assign mask_d = (mask_we && mask_sel == CW'(c)) ? mask_val : mask_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q <= '0;
        pend_q <= '0;
      end else begin
        mask_q <= mask_d;
        pend_q <= here ? (mask_d & raw_d) : '0;
      end
    end

    always_comb begin
      low = '0;
      for (int i = NSRC - 1; i >= 0; i--)
        if (pend_q[i]) low = SW'(i);
    end

    assign pend[c*NSRC +: NSRC] = pend_q;
    assign irq[c]               = |pend_q;
    assign low_src[c*SW +: SW]  = low;
  end

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NSRC = 64,
  parameter int NCPU = 4,
  localparam int SW = $clog2(NSRC),
  localparam int CW = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int PW = $clog2(NCPU + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PW-1:0]        cpu_count,
  input logic                 post_en,
  input logic [SW-1:0]        post_src,
  input logic                 clr_en,
  input logic [SW-1:0]        clr_src,
  input logic                 mask_we,
  input logic [CW-1:0]        mask_sel,
  input logic [NSRC-1:0]      mask_val,
  input logic [NSRC-1:0]      raw_req,
  input logic [NCPU*NSRC-1:0] pend,
  input logic [NCPU-1:0]      irq,
  input logic [NCPU*SW-1:0]   low_src
);

  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (post_en && !(clr_en && clr_src == post_src)) |=> raw_req[$past(post_src)]);

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !raw_req[$past(clr_src)]);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_en && !clr_en) |=> $stable(raw_req));

  for (genvar c = 0; c < NCPU; c++) begin : g_chk
    logic [NSRC-1:0] pc;
    logic [SW-1:0]   lc;
    assign pc = pend[c*NSRC +: NSRC];
    assign lc = low_src[c*SW +: SW];

    p_pend_in_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pc & ~raw_req) == '0);

    p_absent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (PW'(c) >= cpu_count) |=> (pc == '0 && !irq[c]));

    p_irq_points_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> pc[lc]);

    p_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> ((pc & ((NSRC'(1) << lc) - NSRC'(1))) == '0));
  end

endmodule

bind irq_router irq_router_chk #(.NSRC(NSRC), .NCPU(NCPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
  .post_en(post_en), .post_src(post_src), .clr_en(clr_en), .clr_src(clr_src),
  .mask_we(mask_we), .mask_sel(mask_sel), .mask_val(mask_val),
  .raw_req(raw_req), .pend(pend), .irq(irq), .low_src(low_src)
);

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  localparam int NSRC = 64;
  localparam int NCPU = 4;
  localparam int SW = 6;
  localparam int CW = 2;
  localparam int PW = 3;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] cpu_count = PW'(NCPU);
  logic post_en = 0, clr_en = 0, mask_we = 0;
  logic [SW-1:0] post_src = 0, clr_src = 0;
  logic [CW-1:0] mask_sel = 0;
  logic [NSRC-1:0] mask_val = 0;
  logic [NSRC-1:0] raw_req;
  logic [NCPU*NSRC-1:0] pend;
  logic [NCPU-1:0] irq;
  logic [NCPU*SW-1:0] low_src;

  always #2 clk = ~clk;

  irq_router u_dut (.*);

  int total = 0, bad = 0;
  logic [NSRC-1:0] raw_m;
  logic [NSRC-1:0] mask_m [NCPU];
  int cnt_m = NCPU;

  function automatic int lowest(input logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic check(input string req);
    logic ok = 1;
    total++;
    if (raw_req !== raw_m) begin
      ok = 0; $display("FAIL %s raw act=%h exp=%h", req, raw_req, raw_m);
    end
    for (int c = 0; c < NCPU; c++) begin
      logic [NSRC-1:0] ep;
      ep = (c < cnt_m) ? (mask_m[c] & raw_m) : '0;
      if (pend[c*NSRC +: NSRC] !== ep) begin
        ok = 0; $display("FAIL %s pend[%0d] act=%h exp=%h", req, c, pend[c*NSRC +: NSRC], ep);
      end
      if (irq[c] !== (ep != 0)) begin
        ok = 0; $display("FAIL %s irq[%0d] act=%b exp=%b", req, c, irq[c], ep != 0);
      end
      if (int'(low_src[c*SW +: SW]) != lowest(ep)) begin
        ok = 0; $display("FAIL %s low[%0d] act=%0d exp=%0d", req, c, low_src[c*SW +: SW], lowest(ep));
      end
    end
    if (!ok) bad++;
  endtask

  task automatic step(input bit p, input int ps, input bit k, input int ks,
                      input bit w, input int ws, input logic [NSRC-1:0] wv, input int n);
    post_en = p; post_src = SW'(ps); clr_en = k; clr_src = SW'(ks);
    mask_we = w; mask_sel = CW'(ws); mask_val = wv; cpu_count = PW'(n);
    @(posedge clk); #1;
    post_en = 0; clr_en = 0; mask_we = 0;
    if (p) raw_m[ps] = 1'b1;
    if (k) raw_m[ks] = 1'b0;
    if (w) mask_m[ws] = wv;
    cnt_m = n;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    raw_m = '0;
    for (int c = 0; c < NCPU; c++) mask_m[c] = '0;
    repeat (3) @(posedge clk); #1;
    check("R10 reset");
    rst_n = 1;
    step(1, 5, 0, 0, 0, 0, '0, 4); check("R10 masks clear after reset, R1 post");
    step(0, 0, 1, 5, 0, 0, '0, 4); check("R4 clear");
    // R8: mask writes
    step(0, 0, 0, 0, 1, 0, '1, 4); check("R8 mask0");
    step(0, 0, 0, 0, 1, 1, {32{2'b01}}, 4); check("R8 mask1");
    step(0, 0, 0, 0, 1, 2, {{32{1'b1}}, 32'h0}, 4); check("R8 mask2");
    step(0, 0, 0, 0, 1, 3, {1'b1, 63'h0}, 4); check("R8 mask3");
    // R1 R2 R3 R9: post sweep
    for (int s = 0; s < NSRC; s++) begin
      step(1, s, 0, 0, 0, 0, '0, 4); check("R1 R2 R3 R9 post sweep");
    end
    // R4 clear sweep from low end, lowest index moves up
    for (int s = 0; s < NSRC; s++) begin
      step(0, 0, 1, s, 0, 0, '0, 4); check("R4 R9 clear sweep");
    end
    // R5 clear of unset bit
    step(0, 0, 1, 10, 0, 0, '0, 4); check("R5 clear empty");
    step(1, 40, 0, 0, 0, 0, '0, 4);
    step(1, 3, 0, 0, 0, 0, '0, 4);
    step(0, 0, 1, 17, 0, 0, '0, 4); check("R5 clear unset among set");
    // R6 same source post+clear
    step(1, 20, 1, 20, 0, 0, '0, 4); check("R6 clear wins new");
    step(1, 40, 1, 40, 0, 0, '0, 4); check("R6 clear wins set");
    step(1, 63, 1, 3, 0, 0, '0, 4); check("R6 distinct both act");
    // R7 present count sweep
    for (int s = 0; s < NSRC; s += 7) step(1, s, 0, 0, 0, 0, '0, 4);
    for (int n = 0; n <= NCPU; n++) begin
      step(0, 0, 0, 0, 0, 0, '0, n); check("R7 count sweep");
    end
    step(0, 0, 0, 0, 1, 3, '1, 2); check("R7 absent mask write");
    step(0, 0, 0, 0, 0, 0, '0, 4); check("R7 restored");
    // R8 mask change with raw set, R3 line drop
    step(0, 0, 0, 0, 1, 1, '0, 4); check("R8 R3 mask off");
    step(0, 0, 0, 0, 1, 2, 64'h0000_0100_0000_0000, 4); check("R8 narrow mask");
    step(0, 0, 0, 0, 1, 1, 64'h8000_0000_0000_0001, 4); check("R8 R9 two bits");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule